// File: doc/BRIEF.md
# MSI Vector Dispatcher with Per-Vector Masking

This block sits between a function's interrupt sources and its bus master port. Device logic raises a request for one vector number. The block checks that vector against the allocation that software granted through the multiple-message-enable field. It then turns the request into a single 32-bit memory write. The write goes to the programmed message address. Its data is the programmed message word with the vector number merged into the low bits, and it carries the function's requester ID.

When the per-vector mask option is built in and a vector's mask bit is set, the request is not sent. It is recorded in a pending register instead. Every configuration write to the capability while MSI is enabled does three things. It drops the legacy INTx line. It clears the pending bits that fall outside the current allocation. It then replays each pending, unmasked vector, lowest number first, one transaction at a time. The outgoing write uses a plain valid/ready handshake, and only one write is outstanding at a time.

Top module: `msi_dispatch`

## Requirements
- R1: After reset, `mw_valid`, `irq_bad`, `intx_out` and every `pend_bits` bit are 0, and `irq_ready` is 1.
- R2: The allocated count is 2^min(`cfg_mme`, log2(NVEC)). An accepted request whose vector is at or above this count raises `irq_bad` for exactly the next cycle. It issues no write and sets no pending bit. With NVEC=32, `cfg_mme` values of 5 to 7 all allocate 32 vectors.
- R3: An accepted, legal, unmasked request presents a write in the next cycle. The write address is `cfg_addr` with bits 1:0 forced to zero, and the requester ID is `cfg_rid`.
- R4: Write data bits 31:16 are zero. Bits 15:0 equal `cfg_data`, except that the low log2(count) bits are replaced by the vector number.
- R5: An accepted, legal request whose mask bit is set sets that vector's bit in `pend_bits` in the next cycle and issues no write. Repeating the request leaves the bit set and issues nothing further.
- R6: With HAS_MASK=0, `cfg_mask` is ignored, every legal request is sent, and `pend_bits` stays zero.
- R7: While `mw_valid` is high and `mw_ready` is low, the write address, data and ID hold steady. During that time and during a replay, `irq_ready` is low, so at most one write is outstanding.
- R8: `intx_set` drives `intx_out` high from the next cycle. A cycle with `cfg_touch` and `cfg_en` both high drives `intx_out` low in the next cycle, even if `intx_set` is high in that same cycle.
- R9: A cycle with `cfg_touch` and `cfg_en` both high clears, in the next cycle, every pending bit at or above the allocated count.
- R10: After such a write, each pending, unmasked vector within the allocation is issued in ascending vector order. Its pending bit is cleared when its write is loaded, and the next vector is loaded only after the previous write is accepted.
- R11: A `cfg_touch` cycle with `cfg_en` low changes neither `pend_bits` nor `intx_out`, and starts no replay.
- R12: A masked request accepted in the same cycle as an enabled `cfg_touch` is kept as pending, while the trimming of R9 still applies to the older bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | MSI enable from the capability control word |
| cfg_mme | input | 3 | Multiple-message-enable field (log2 of the allocated count) |
| cfg_addr | input | 64 | Programmed message address |
| cfg_data | input | 16 | Programmed message data |
| cfg_mask | input | NVEC | Per-vector mask bits |
| cfg_rid | input | 16 | Requester ID of the function |
| cfg_touch | input | 1 | One-cycle pulse: a configuration write hit the capability |
| irq_valid | input | 1 | Interrupt request from device logic |
| irq_vec | input | log2(NVEC) | Requested vector number |
| irq_ready | output | 1 | Request can be accepted this cycle |
| irq_bad | output | 1 | One-cycle flag for an out-of-range vector |
| intx_set | input | 1 | Legacy interrupt assertion pulse |
| intx_out | output | 1 | Legacy INTx level |
| pend_bits | output | NVEC | Pending register of the capability |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory write request accepted |
| mw_addr | output | 64 | Write address |
| mw_data | output | 32 | Write data |
| mw_rid | output | 16 | Requester ID attached to the write |

## Verification
Two updates can land on the pending register in the same cycle. One is a masked request setting a bit. The other is an enabled configuration write trimming bits beyond a newly shrunk allocation. The bench masks vectors 1, 3 and 7 and leaves them pending. It then lowers the allocation to four vectors and requests masked vector 2 in the very cycle of the configuration write. The pending register must come out holding vectors 1, 2 and 3, with vector 7 dropped and no write issued. After all vectors are unmasked, the replay must deliver 1, 2 and 3 in that order.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned RID_W  = 16;
    localparam int unsigned MME_W  = 3;

    // One outgoing memory-write message
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [RID_W-1:0]  rid;
    } msi_msg_t;

    // Classification of an accepted request
    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_SEND,
        REQ_HOLD,
        REQ_BAD
    } req_kind_e;

    // Message address is dword aligned
    function automatic logic [ADDR_W-1:0] msg_addr(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(3);
    endfunction

    // Merge the vector number into the low lg bits of the data word
    function automatic logic [DATA_W-1:0] msg_data(input logic [15:0] base,
                                                  input logic [15:0] vec,
                                                  input logic [MME_W-1:0] lg);
        logic [15:0] hi_keep;
        hi_keep = 16'hFFFF << lg;
        return {16'h0000, (base & hi_keep) | (vec & ~hi_keep)};
    endfunction

endpackage

// File: rtl/msi_prio_pick.sv
`timescale 1ns/1ps
module msi_prio_pick #(
    parameter int unsigned N = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    // Lowest-index-first chain: grant goes to the first set candidate
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = cand[i] & ~seen[i];
        assign seen[i+1] = seen[i] | cand[i];
    end

    always_comb begin
        idx = '0;
        for (int unsigned i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    assign found = seen[N];

endmodule

// File: rtl/msi_pend_ctl.sv
`timescale 1ns/1ps
module msi_pend_ctl #(
    parameter int unsigned NVEC     = 32,
    parameter bit          HAS_MASK = 1'b1,
    localparam int unsigned IW      = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    input  logic            trim_en,
    input  logic [NVEC-1:0] keep,
    output logic [NVEC-1:0] pend
);

    if (HAS_MASK) begin : g_store
        logic [NVEC-1:0] bits_q;
        logic [NVEC-1:0] bits_d;

        // Trim old bits first, then retire the replayed one, then record the new one
        always_comb begin
            bits_d = bits_q;
            if (trim_en) bits_d = bits_d & keep;
            if (clr_en)  bits_d[clr_idx] = 1'b0;
            if (set_en)  bits_d[set_idx] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) bits_q <= '0;
            else     bits_q <= bits_d;
        end

        assign pend = bits_q;

        // R9: nothing outside the allocation survives a trim
        a_r9_trim_clears: assert property (@(posedge clk) disable iff (rst)
            trim_en |=> ((pend & ~$past(keep)) == '0));

        // R5: a recorded request is visible the next cycle
        a_r5_set_seen: assert property (@(posedge clk) disable iff (rst)
            set_en |=> pend[$past(set_idx)]);
    end else begin : g_none
        logic unused_in;
        assign unused_in = ^{clk, rst, set_en, set_idx, clr_en, clr_idx, trim_en, keep};
        assign pend = '0;
    end

endmodule

// File: rtl/msi_wr_out.sv
`timescale 1ns/1ps
module msi_wr_out
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_en,
    input  msi_msg_t load_msg,
    input  logic     ready,
    output logic     valid,
    output msi_msg_t msg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
        end else if (load_en) begin
            valid <= 1'b1;
            msg   <= load_msg;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R7: an unaccepted write keeps its content
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(msg)));

    // R7: never load over an outstanding write
    a_r7_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !valid);

endmodule

// File: rtl/msi_dispatch.sv
`timescale 1ns/1ps
module msi_dispatch
    import msi_pkg::*;
#(
    parameter int unsigned NVEC     = 32,
    parameter bit          HAS_MASK = 1'b1,
    localparam int unsigned VW      = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [MME_W-1:0]  cfg_mme,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_data,
    input  logic [NVEC-1:0]   cfg_mask,
    input  logic [RID_W-1:0]  cfg_rid,
    input  logic              cfg_touch,
    input  logic              irq_valid,
    input  logic [VW-1:0]     irq_vec,
    output logic              irq_ready,
    output logic              irq_bad,
    input  logic              intx_set,
    output logic              intx_out,
    output logic [NVEC-1:0]   pend_bits,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic [RID_W-1:0]  mw_rid
);

    localparam logic [MME_W-1:0] LG_MAX = MME_W'(VW);

    logic [MME_W-1:0] lg_eff;
    logic [NVEC-1:0]  alloc_keep;
    logic [NVEC-1:0]  mask_eff;
    logic             vec_legal;
    req_kind_e        kind;
    logic             cfg_live;
    logic             replay_q;
    logic [NVEC-1:0]  replay_cand;
    logic             pick_found;
    logic [VW-1:0]    pick_idx;
    logic             replay_fire;
    logic             replay_end;
    logic             load_en;
    logic [VW-1:0]    load_vec;
    msi_msg_t         load_msg;
    msi_msg_t         out_msg;

    // Allocation: requested order clamped to what the block was built with
    assign lg_eff = (cfg_mme > LG_MAX) ? LG_MAX : cfg_mme;

    always_comb begin
        for (int unsigned i = 0; i < NVEC; i++) begin
            alloc_keep[i] = ((32'(i) >> lg_eff) == 32'd0);
        end
    end

    assign mask_eff  = HAS_MASK ? cfg_mask : '0;
    assign vec_legal = ((32'(irq_vec) >> lg_eff) == 32'd0);

    // Request classification
    assign irq_ready = !mw_valid && !replay_q;

    always_comb begin
        kind = REQ_NONE;
        if (irq_valid && irq_ready) begin
            if (!vec_legal)              kind = REQ_BAD;
            else if (mask_eff[irq_vec])  kind = REQ_HOLD;
            else                         kind = REQ_SEND;
        end
    end

    // Replay of pending vectors
    assign cfg_live    = cfg_touch && cfg_en;
    assign replay_cand = pend_bits & ~mask_eff & alloc_keep;

    msi_prio_pick #(.N(NVEC)) u_pick (
        .cand  (replay_cand),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign replay_fire = replay_q && !mw_valid && pick_found;
    assign replay_end  = replay_q && !mw_valid && !pick_found;

    always_ff @(posedge clk) begin
        if (rst)                       replay_q <= 1'b0;
        else if (cfg_live && HAS_MASK) replay_q <= 1'b1;
        else if (replay_end)           replay_q <= 1'b0;
    end

    msi_pend_ctl #(.NVEC(NVEC), .HAS_MASK(HAS_MASK)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (kind == REQ_HOLD),
        .set_idx (irq_vec),
        .clr_en  (replay_fire),
        .clr_idx (pick_idx),
        .trim_en (cfg_live),
        .keep    (alloc_keep),
        .pend    (pend_bits)
    );

    // Message assembly
    assign load_en  = (kind == REQ_SEND) || replay_fire;
    assign load_vec = replay_fire ? pick_idx : irq_vec;

    always_comb begin
        load_msg.addr = msg_addr(cfg_addr);
        load_msg.data = msg_data(cfg_data, 16'(load_vec), lg_eff);
        load_msg.rid  = cfg_rid;
    end

    msi_wr_out u_out (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_msg (load_msg),
        .ready    (mw_ready),
        .valid    (mw_valid),
        .msg      (out_msg)
    );

    assign mw_addr = out_msg.addr;
    assign mw_data = out_msg.data;
    assign mw_rid  = out_msg.rid;

    // Error flag and legacy line
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_bad  <= 1'b0;
            intx_out <= 1'b0;
        end else begin
            irq_bad <= (kind == REQ_BAD);
            if (cfg_live)      intx_out <= 1'b0;
            else if (intx_set) intx_out <= 1'b1;
        end
    end

    // R2: out-of-range request flags and stays silent
    a_r2_bad_silent: assert property (@(posedge clk) disable iff (rst)
        (kind == REQ_BAD) |=> (irq_bad && !mw_valid));

    // R3: a sent request is presented next cycle with the function's ID
    a_r3_send_next: assert property (@(posedge clk) disable iff (rst)
        (kind == REQ_SEND) |=> (mw_valid && mw_rid == $past(cfg_rid)));

    // R5: a masked request produces no write
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (kind == REQ_HOLD) |=> (!mw_valid && pend_bits[$past(irq_vec)]));

    // R8: enabled configuration write drops INTx
    a_r8_intx_drop: assert property (@(posedge clk) disable iff (rst)
        (cfg_touch && cfg_en) |=> !intx_out);

    // R11: disabled configuration write leaves state alone
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_touch && !cfg_en && !replay_q && !irq_valid && !intx_set)
        |=> ($stable(pend_bits) && $stable(intx_out)));

endmodule

// File: tb/msi_dispatch_bench.sv
`timescale 1ns/1ps
module msi_dispatch_bench;
    import msi_pkg::*;

    localparam int unsigned NV = 32;
    localparam logic [63:0] PROG_ADDR = 64'h0000_00AB_FEE0_1003;
    localparam logic [63:0] EXP_ADDR  = 64'h0000_00AB_FEE0_1000;
    localparam logic [15:0] PROG_DATA = 16'h4A5C;
    localparam logic [15:0] PROG_RID  = 16'h0123;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        cfg_en;
    logic [2:0]  cfg_mme;
    logic [63:0] cfg_addr;
    logic [15:0] cfg_data;
    logic [31:0] cfg_mask;
    logic [15:0] cfg_rid;
    logic        cfg_touch;
    logic        irq_valid;
    logic [4:0]  irq_vec;
    logic        irq_ready, irq_bad;
    logic        intx_set, intx_out;
    logic [31:0] pend_bits;
    logic        mw_valid, mw_ready;
    logic [63:0] mw_addr;
    logic [31:0] mw_data;
    logic [15:0] mw_rid;

    logic        nm_ready, nm_bad, nm_intx, nm_valid;
    logic [31:0] nm_pend;
    logic [63:0] nm_addr;
    logic [31:0] nm_data;
    logic [15:0] nm_rid;

    msi_dispatch #(.NVEC(NV), .HAS_MASK(1'b1)) u_msi_dispatch (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mme(cfg_mme), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_rid(cfg_rid), .cfg_touch(cfg_touch),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready), .irq_bad(irq_bad),
        .intx_set(intx_set), .intx_out(intx_out), .pend_bits(pend_bits),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_rid(mw_rid)
    );

    // Variant without masking, for R6
    msi_dispatch #(.NVEC(NV), .HAS_MASK(1'b0)) u_nomask (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mme(cfg_mme), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_rid(cfg_rid), .cfg_touch(cfg_touch),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(nm_ready), .irq_bad(nm_bad),
        .intx_set(intx_set), .intx_out(nm_intx), .pend_bits(nm_pend),
        .mw_valid(nm_valid), .mw_ready(1'b1), .mw_addr(nm_addr), .mw_data(nm_data),
        .mw_rid(nm_rid)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int nm_beats = 0;
    bit nm_pend_seen = 1'b0;

    typedef struct {
        logic [63:0] a;
        logic [31:0] d;
        logic [15:0] r;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected data: clear the low lg bits of the base and put the vector there
    function automatic logic [31:0] edata(input int vec, input int lg);
        int          cnt;
        logic [15:0] low;
        cnt = 1 << lg;
        low = 16'(cnt - 1);
        return {16'h0000, (PROG_DATA & ~low) | (16'(vec) & low)};
    endfunction

    task automatic expect_msg(input int vec, input int lg, input string tag);
        exp_t e;
        e.a = EXP_ADDR;
        e.d = edata(vec, lg);
        e.r = PROG_RID;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic irq(input logic [4:0] v);
        while (!irq_ready) step();
        irq_valid = 1'b1;
        irq_vec   = v;
        step();
        irq_valid = 1'b0;
        step();
        step();
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 60 && sb.size() != 0; i++) step();
        step();
        chk(sb.size() == 0, tag, "writes outstanding", 64'(sb.size()), 64'd0);
    endtask

    // Monitor: pops the scoreboard on each accepted write
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (mw_valid && mw_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write data", 64'(mw_data), 64'd0);
                end else begin
                    e = sb.pop_front();
                    chk(mw_addr == e.a, e.tag, "write address", mw_addr, e.a);
                    chk(mw_data == e.d, e.tag, "write data", 64'(mw_data), 64'(e.d));
                    chk(mw_rid == e.r, e.tag, "requester id", 64'(mw_rid), 64'(e.r));
                end
            end
            if (nm_valid) nm_beats++;
            if (nm_pend != 32'd0) nm_pend_seen = 1'b1;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nm0;
        rst = 1'b1;
        cfg_en = 1'b0; cfg_mme = 3'd0; cfg_addr = PROG_ADDR; cfg_data = PROG_DATA;
        cfg_mask = 32'd0; cfg_rid = PROG_RID; cfg_touch = 1'b0;
        irq_valid = 1'b0; irq_vec = 5'd0; intx_set = 1'b0; mw_ready = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();

        // R1: reset state
        @(negedge clk);
        chk(!mw_valid, "R1", "mw_valid", 64'(mw_valid), 64'd0);
        chk(pend_bits == 32'd0, "R1", "pend_bits", 64'(pend_bits), 64'd0);
        chk(!irq_bad && !intx_out, "R1", "bad/intx", 64'({irq_bad, intx_out}), 64'd0);
        chk(irq_ready, "R1", "irq_ready", 64'(irq_ready), 64'd1);
        step();

        // R3/R4/R7: single vector, write stalled for a few cycles
        cfg_en = 1'b1; cfg_mme = 3'd0; mw_ready = 1'b0;
        step();
        expect_msg(0, 0, "R4");
        irq_valid = 1'b1; irq_vec = 5'd0;
        step();
        irq_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(mw_valid && !irq_ready, "R7", "stall valid/ready", 64'({mw_valid, irq_ready}), 64'h2);
            chk(mw_data == edata(0, 0), "R7", "held data", 64'(mw_data), 64'(edata(0, 0)));
            step();
        end
        mw_ready = 1'b1;
        drain("R3");

        // R4: eight vectors allocated
        cfg_mme = 3'd3;
        expect_msg(5, 3, "R4"); irq(5'd5);
        expect_msg(7, 3, "R4"); irq(5'd7);
        drain("R4");

        // R2: vector 8 with eight allocated
        while (!irq_ready) step();
        irq_valid = 1'b1; irq_vec = 5'd8;
        step();
        irq_valid = 1'b0;
        @(negedge clk);
        chk(irq_bad, "R2", "irq_bad pulse", 64'(irq_bad), 64'd1);
        step();
        @(negedge clk);
        chk(!irq_bad && !mw_valid, "R2", "after bad", 64'({irq_bad, mw_valid}), 64'd0);
        chk(pend_bits == 32'd0, "R2", "no pending", 64'(pend_bits), 64'd0);
        step();

        // R2: order above the built size clamps to 32 vectors
        cfg_mme = 3'd7;
        expect_msg(31, 5, "R2"); irq(5'd31);
        drain("R2");

        // R5/R6: masked requests, repeat on an already pending vector
        cfg_mme = 3'd3; cfg_mask = 32'h0000_008A;
        step();
        nm0 = nm_beats;
        irq(5'd3); irq(5'd7); irq(5'd1); irq(5'd3);
        @(negedge clk);
        chk(pend_bits == 32'h8A, "R5", "pending after masked", 64'(pend_bits), 64'h8A);
        chk(!mw_valid && sb.size() == 0, "R5", "no write", 64'(mw_valid), 64'd0);
        chk(nm_beats - nm0 == 4, "R6", "unmasked variant writes", 64'(nm_beats - nm0), 64'd4);
        step();

        // R12/R9: masked request in the same cycle as a shrinking config write
        cfg_mask = 32'h0000_008E;
        step();
        while (!irq_ready) step();
        cfg_mme = 3'd2; cfg_touch = 1'b1; irq_valid = 1'b1; irq_vec = 5'd2;
        step();
        cfg_touch = 1'b0; irq_valid = 1'b0;
        step(); step();
        @(negedge clk);
        chk(pend_bits == 32'h0E, "R12", "pending after collision", 64'(pend_bits), 64'h0E);
        chk(pend_bits[7] == 1'b0, "R9", "bit beyond count", 64'(pend_bits[7]), 64'd0);
        chk(!mw_valid, "R12", "no write while masked", 64'(mw_valid), 64'd0);
        step();

        // R10: replay after unmask, ascending, one per accepted write
        mw_ready = 1'b0; cfg_mask = 32'd0;
        expect_msg(1, 2, "R10"); expect_msg(2, 2, "R10"); expect_msg(3, 2, "R10");
        cfg_touch = 1'b1;
        step();
        cfg_touch = 1'b0;
        step();
        @(negedge clk);
        chk(mw_valid, "R10", "first replay valid", 64'(mw_valid), 64'd1);
        chk(pend_bits == 32'h0C, "R10", "pending after first load", 64'(pend_bits), 64'h0C);
        chk(!irq_ready, "R7", "ready during replay", 64'(irq_ready), 64'd0);
        step();
        mw_ready = 1'b1;
        drain("R10");
        chk(pend_bits == 32'd0, "R10", "pending drained", 64'(pend_bits), 64'd0);

        // R8/R11: disabled config write leaves INTx and pending alone
        intx_set = 1'b1;
        step();
        intx_set = 1'b0;
        @(negedge clk);
        chk(intx_out, "R8", "intx set", 64'(intx_out), 64'd1);
        step();
        cfg_mask = 32'h1;
        step();
        irq(5'd0);
        cfg_en = 1'b0; cfg_mask = 32'd0; cfg_touch = 1'b1;
        step();
        cfg_touch = 1'b0;
        repeat (4) step();
        @(negedge clk);
        chk(pend_bits == 32'h1, "R11", "pending kept", 64'(pend_bits), 64'h1);
        chk(intx_out, "R11", "intx kept", 64'(intx_out), 64'd1);
        chk(!mw_valid && sb.size() == 0, "R11", "no replay", 64'(mw_valid), 64'd0);
        step();
        expect_msg(0, 2, "R8");
        cfg_en = 1'b1; cfg_touch = 1'b1;
        step();
        cfg_touch = 1'b0;
        @(negedge clk);
        chk(!intx_out, "R8", "intx dropped", 64'(intx_out), 64'd0);
        step();
        drain("R8");

        // R8: set and drop in the same cycle, drop wins
        intx_set = 1'b1;
        step();
        intx_set = 1'b1; cfg_touch = 1'b1;
        step();
        intx_set = 1'b0; cfg_touch = 1'b0;
        @(negedge clk);
        chk(!intx_out, "R8", "drop beats set", 64'(intx_out), 64'd0);
        step();
        step();

        chk(!nm_pend_seen, "R6", "no pending without masking", 64'(nm_pend_seen), 64'd0);
        chk(sb.size() == 0, "R10", "scoreboard empty", 64'(sb.size()), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule